// File: doc/BRIEF.md
# Five-bit word serializer

This block turns a short parallel word into a serial bit stream, one bit per rising clock edge, least significant bit first. A producer presents a word together with a valid strobe. When the block is idle and sees the strobe on a clock edge, it puts bit 0 on the serial line on that same edge, so no idle cycle is lost. It then sends the remaining bits on the following edges.

Two handshake flags go with the serial line. The busy flag is high in every cycle in which a valid bit is on the line. The done flag is a one-cycle pulse that appears together with the last bit and asks the producer for the next word. If the strobe is still high when the last bit has been sent, the next word starts on the following edge, so words follow each other with no gap. The word is copied into an internal holding register on the start edge, so the producer may change the input afterwards. Every output is taken directly from a flip-flop, which means none of them can glitch when the strobe changes.

Top module: `word_serializer`

## Requirements
- R1: After the k-th edge of a frame (k = 1 to 5), `ser_bit` equals bit k-1 of the word, so bits leave least significant first.
- R2: When the block is idle and `word_vld` is high at a rising edge, bit 0 of `par_word` and a high `busy` appear right after that same edge.
- R3: A frame is exactly five bits long. After the edge that drives bit 4, the block is idle again.
- R4: `word_done` is high in the cycle in which bit 4 is on the line, and low while bits 0 to 3 are on the line.
- R5: `word_done` is a single-cycle pulse. It is never high in two consecutive cycles.
- R6: `busy` is high in every cycle in which a frame bit is on the line. It is low after an idle edge at which `word_vld` was low.
- R7: While the block is idle, `ser_bit` is 0.
- R8: When `rst_n` is low, `ser_bit`, `word_done` and `busy` are 0 and the block is idle.
- R9: The word is captured on the start edge. Changes to `par_word` after that edge do not change the bits of the frame that is being sent.
- R10: If `word_vld` is high at the edge after bit 4 was driven, the next frame starts on that edge. `busy` stays high and bit 0 of the new word follows bit 4 with no gap.
- R11: `word_vld` is ignored while bits 1 to 4 are being sent. It neither restarts nor stretches the frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock. All state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| par_word | input | 5 | Parallel word to send |
| word_vld | input | 1 | High when par_word holds a word to send |
| ser_bit | output | 1 | Serial data, one bit per clock, from a flip-flop |
| word_done | output | 1 | One-cycle pulse together with the last bit of a frame |
| busy | output | 1 | High while a frame bit is on ser_bit |

## Verification
The bench changes `par_word` in every cycle of a frame. A design that reads the live input, instead of the captured copy, then sends mixed bits. It holds `word_vld` high across the last bit to test back-to-back frames. A design that spends an idle cycle at the frame boundary would drop `busy` or delay bit 0 by one clock. It pulses `word_vld` in the middle of a frame, which would restart or lengthen the frame in a design that ignores the index. It also compares the timing of `word_done` to the cycle of bit 4, so a flag that comes one cycle early or late, or one that stays high for two cycles, is reported.

// File: rtl/ser5_pkg.sv
package ser5_pkg;

  // Per-cycle control decoded from the bit index and the valid strobe.
  typedef struct packed {
    logic start;  // idle index and strobe high: launch bit 0 this edge
    logic shift;  // inside a frame: send the bit at the current index
    logic last;   // the bit sent this edge is the final one
  } step_t;

endpackage

// File: rtl/ser5_seq.sv
module ser5_seq
  import ser5_pkg::*;
#(
  parameter int WORD_W = 5,
  parameter int IDX_W  = $clog2(WORD_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             word_vld,
  output logic [IDX_W-1:0] idx_q,
  output step_t            step
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORD_W - 1);
  localparam logic [IDX_W-1:0] ONE_IDX  = IDX_W'(1);

  logic [IDX_W-1:0] idx_d;
  logic             idx_en;

  always_comb begin
    step.start = (idx_q == '0) && word_vld;
    step.shift = (idx_q != '0);
    step.last  = step.shift && (idx_q == LAST_IDX);
    idx_en     = step.start || step.shift;
    if (step.start) begin
      idx_d = ONE_IDX;
    end else if (step.last) begin
      idx_d = '0;
    end else begin
      idx_d = idx_q + ONE_IDX;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (idx_en) begin
      idx_q <= idx_d;
    end
  end

endmodule

// File: rtl/ser5_hold.sv
module ser5_hold
  import ser5_pkg::*;
#(
  parameter int WORD_W = 5,
  parameter int IDX_W  = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  step_t             step,
  input  logic [IDX_W-1:0]  idx_q,
  input  logic [WORD_W-1:0] par_word,
  output logic              ser_bit
);

  logic [WORD_W-1:0] hold_q;
  logic              bit_d;

  // The copy of the word is loaded only on the start edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (step.start) begin
      hold_q <= par_word;
    end
  end

  // Bit 0 comes from the live input, because the copy is only being loaded
  // on this edge. Later bits come from the copy.
  always_comb begin
    if (step.start) begin
      bit_d = par_word[0];
    end else if (step.shift) begin
      bit_d = hold_q[idx_q];
    end else begin
      bit_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ser_bit <= 1'b0;
    end else begin
      ser_bit <= bit_d;
    end
  end

endmodule

// File: rtl/ser5_flags.sv
module ser5_flags
  import ser5_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  step_t step,
  output logic  word_done,
  output logic  busy
);

  logic busy_d;
  logic done_d;

  always_comb begin
    busy_d = step.start || step.shift;
    done_d = step.last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      word_done <= 1'b0;
    end else begin
      busy      <= busy_d;
      word_done <= done_d;
    end
  end

endmodule

// File: rtl/word_serializer.sv
module word_serializer
  import ser5_pkg::*;
#(
  parameter int WORD_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] par_word,
  input  logic              word_vld,
  output logic              ser_bit,
  output logic              word_done,
  output logic              busy
);

  localparam int IDX_W = $clog2(WORD_W);

  logic [IDX_W-1:0] idx_q;
  step_t            step;

  ser5_seq #(.WORD_W(WORD_W), .IDX_W(IDX_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .word_vld (word_vld),
    .idx_q    (idx_q),
    .step     (step)
  );

  ser5_hold #(.WORD_W(WORD_W), .IDX_W(IDX_W)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (step),
    .idx_q    (idx_q),
    .par_word (par_word),
    .ser_bit  (ser_bit)
  );

  ser5_flags u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .step      (step),
    .word_done (word_done),
    .busy      (busy)
  );

endmodule

// File: rtl/ser5_chk.sv
module ser5_chk #(
  parameter int WORD_W = 5,
  parameter int IDX_W  = $clog2(WORD_W)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [WORD_W-1:0] par_word,
  input logic              word_vld,
  input logic              ser_bit,
  input logic              word_done,
  input logic              busy,
  input logic [IDX_W-1:0]  idx_q
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORD_W - 1);

  // R2: an idle edge with the strobe high launches bit 0 and raises busy
  a_r2_launch: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_q == '0 && word_vld) |=> (busy && ser_bit == $past(par_word[0])));

  // R3: the index returns to idle after the last bit
  a_r3_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_q == LAST_IDX) |=> (idx_q == '0));

  // R4: done only follows the edge that sent the last index
  a_r4_done_last: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(word_done) |-> ($past(idx_q) == LAST_IDX));

  // R5: done never lasts two cycles
  a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |=> !word_done);

  // R6: an idle edge without the strobe drops busy and done
  a_r6_idle_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_q == '0 && !word_vld) |=> (!busy && !word_done));

  // R7: serial line is low while not busy
  a_r7_idle_line: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !ser_bit);

  // R11: inside a frame the index moves on by one whatever the strobe does
  a_r11_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_q != '0 && idx_q != LAST_IDX) |=> (idx_q == $past(idx_q) + IDX_W'(1)));

endmodule

bind word_serializer ser5_chk #(.WORD_W(WORD_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .par_word  (par_word),
  .word_vld  (word_vld),
  .ser_bit   (ser_bit),
  .word_done (word_done),
  .busy      (busy),
  .idx_q     (idx_q)
);

// File: tb/test_word_serializer.sv
module test_word_serializer;

  localparam int W = 5;

  logic         clk;
  logic         rst_n;
  logic [W-1:0] par_word;
  logic         word_vld;
  logic         ser_bit;
  logic         word_done;
  logic         busy;

  int n_chk;
  int n_fail;
  bit finished;

  // reference state, built from the requirements
  int           m_idx;
  logic [W-1:0] m_word;
  logic         e_ser;
  logic         e_done;
  logic         e_busy;
  string        ser_tag;
  string        ph_tag;

  word_serializer #(.WORD_W(W)) i_word_serializer (
    .clk       (clk),
    .rst_n     (rst_n),
    .par_word  (par_word),
    .word_vld  (word_vld),
    .ser_bit   (ser_bit),
    .word_done (word_done),
    .busy      (busy)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", tag, ph_tag, act, exp, $time);
    end
  endtask

  // Reference update for the edge that is coming next.
  task automatic model_edge(input logic vld, input logic [W-1:0] w);
    if (m_idx == 0) begin
      if (vld) begin
        m_word  = w;
        e_ser   = w[0];
        e_busy  = 1'b1;
        e_done  = 1'b0;
        m_idx   = 1;
        ser_tag = "R2";
      end else begin
        e_ser   = 1'b0;
        e_busy  = 1'b0;
        e_done  = 1'b0;
        ser_tag = "R7";
      end
    end else begin
      e_ser   = m_word[m_idx];
      e_busy  = 1'b1;
      e_done  = (m_idx == W - 1);
      m_idx   = (m_idx == W - 1) ? 0 : m_idx + 1;
      ser_tag = "R1";
    end
  endtask

  // At a falling edge: check the outputs of the last rising edge, then drive.
  task automatic cyc(input logic vld, input logic [W-1:0] w);
    @(negedge clk);
    chk(ser_tag, ser_bit, e_ser);
    chk("R4", word_done, e_done);
    chk("R6", busy, e_busy);
    word_vld = vld;
    par_word = w;
    model_edge(vld, w);
  endtask

  initial begin
    n_chk = 0;
    n_fail = 0;
    finished = 1'b0;
    rst_n = 1'b0;
    word_vld = 1'b0;
    par_word = '0;
    m_idx = 0;
    m_word = '0;
    e_ser = 1'b0;
    e_done = 1'b0;
    e_busy = 1'b0;
    ser_tag = "R7";
    ph_tag = "R8";
    void'($urandom(32'h5EED_0005));

    // R8: reset state, even with the strobe high
    word_vld = 1'b1;
    par_word = 5'b11111;
    repeat (3) @(negedge clk);
    chk("R8", ser_bit, 1'b0);
    chk("R8", word_done, 1'b0);
    chk("R8", busy, 1'b0);
    word_vld = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    model_edge(1'b0, '0);

    // R1, R2, R3: a single frame, then idle
    ph_tag = "R3";
    cyc(1'b1, 5'b10110);
    for (int i = 0; i < 7; i++) cyc(1'b0, '0);

    // R9: the input changes in every cycle of the frame
    ph_tag = "R9";
    cyc(1'b1, 5'b01101);
    for (int i = 0; i < 4; i++) cyc(1'b0, ~par_word);
    for (int i = 0; i < 3; i++) cyc(1'b0, '0);

    // R10: strobe held high across frames, so frames run back to back
    ph_tag = "R10";
    for (int f = 0; f < 3; f++) begin
      cyc(1'b1, 5'(f * 7 + 9));
      for (int i = 0; i < 4; i++) cyc(1'b1, 5'($urandom));
    end
    for (int i = 0; i < 3; i++) cyc(1'b0, '0);

    // R11: strobe pulses in the middle of a frame
    ph_tag = "R11";
    cyc(1'b1, 5'b10011);
    cyc(1'b0, 5'b01100);
    cyc(1'b1, 5'b01100);
    cyc(1'b0, '0);
    cyc(1'b1, 5'b11100);
    for (int i = 0; i < 3; i++) cyc(1'b0, '0);

    // R5 and everything else: random stimulus
    ph_tag = "R5";
    for (int i = 0; i < 400; i++) cyc(($urandom % 3) != 0, 5'($urandom));
    for (int i = 0; i < 6; i++) cyc(1'b0, '0);

    // R8: reset in the middle of a frame
    ph_tag = "R8";
    cyc(1'b1, 5'b11111);
    cyc(1'b0, '0);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R8", ser_bit, 1'b0);
    chk("R8", word_done, 1'b0);
    chk("R8", busy, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    m_idx = 0;
    model_edge(1'b0, '0);
    cyc(1'b1, 5'b00001);
    for (int i = 0; i < 6; i++) cyc(1'b0, '0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

endmodule